// File: doc/BRIEF.md
# Byte-Serial Cipher Block Buffer

This block sits between a host that moves data one byte at a time and a cipher engine that works on whole 128-bit blocks. On the input side it gathers bytes into a block register. When sixteen bytes have arrived, or when the host marks a byte as the last of its message, it pulses a start strobe to the engine. With the strobe it presents the block, zero-filled past the last byte received, and a count of the valid bytes.

On the output side the buffer captures the engine's 128-bit result when the engine reports done. It then hands the result back to the host as sixteen bytes over a valid/ready handshake, most significant byte first. The input side stays closed from the start strobe until the sixteenth result byte has left. Only one block is ever in flight, so neither side needs a queue.

Top module: `blk_byte_buffer`

## Requirements
- R1: After a synchronous active-low reset, `in_ready` is 1 and both `out_valid` and `blk_start` are 0.
- R2: The first byte accepted for a block lands in `blk_data[127:120]`, the next in `blk_data[119:112]`, and so on toward bit 0.
- R3: When the sixteenth byte of a block is accepted (`in_valid` and `in_ready` both high at a clock edge), `blk_start` is 1 in the following cycle and `blk_count` reads 16.
- R4: When a byte with `in_last` high is accepted as byte n of a block (1 ≤ n ≤ 16), `blk_start` is 1 in the following cycle, `blk_count` reads n, and every byte position from n onward in `blk_data` is zero.
- R5: `blk_start` is high for exactly one cycle per block.
- R6: `in_ready` is 0 from the cycle `blk_start` is high until the cycle of the sixteenth output handshake, and it is 1 again in the cycle after that handshake.
- R7: A cycle with `eng_done` high while no result is held makes `out_valid` 1 in the next cycle, with `out_data` equal to `eng_result[127:120]`.
- R8: An output byte advances only at an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_data` hold their values.
- R9: The output bytes appear in order from `eng_result[127:120]` down to `eng_result[7:0]`. After the sixteenth handshake `out_valid` is 0.
- R10: `eng_done` pulses that arrive while `out_valid` is 1 do not change the bytes still to be sent.
- R11: Bytes offered on `in_valid` while `in_ready` is 0 are dropped. They produce no `blk_start`, and they are absent from the next block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Host offers a byte |
| in_data | input | 8 | Offered byte |
| in_last | input | 1 | Offered byte ends the message |
| in_ready | output | 1 | Buffer accepts bytes |
| blk_start | output | 1 | One-cycle strobe: block ready for the engine |
| blk_data | output | 128 | Assembled block, zero-padded |
| blk_count | output | 5 | Number of valid bytes in the block (1 to 16) |
| eng_done | input | 1 | Engine result is valid |
| eng_result | input | 128 | Engine result block |
| out_valid | output | 1 | Result byte available |
| out_data | output | 8 | Current result byte |
| out_ready | input | 1 | Host takes the result byte |

## Verification
Several properties are checked on every cycle: the strobe lasts one cycle, the count stays in range, the padding bytes are zero, a closed input stays closed until release, the held block does not change, a stalled output byte stays put, and the output goes idle after the final handshake. Other points cannot be checked cycle by cycle and are shown only by the bench's scenarios. These are the exact placement of each byte, the count reported for messages of many lengths, the byte order of the drained result, and the fact that late engine pulses and bytes offered to a closed input leave no trace.

// File: rtl/blkbuf_pkg.sv
// Shared types for the byte-serial block buffer.
// Assumes nothing beyond being compiled before the modules that import it.
package blkbuf_pkg;
    typedef enum logic {
        FILL_OPEN = 1'b0,
        FILL_HELD = 1'b1
    } fill_state_e;
endpackage

// File: rtl/blkbuf_collect.sv
// Input collector: gathers bytes, first byte into the most significant slot,
// and fires a one-cycle start strobe when a block is full or marked last.
// Assumes release_i pulses exactly once per block, after the strobe.
module blkbuf_collect
    import blkbuf_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int BLK_BYTES = 16,
    localparam int BLK_W    = BYTE_W * BLK_BYTES,
    localparam int CNT_W    = $clog2(BLK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  logic              release_i,
    output logic              in_ready,
    output logic              blk_start,
    output logic [BLK_W-1:0]  blk_data,
    output logic [CNT_W-1:0]  blk_count
);
    fill_state_e      state_q;
    logic [BLK_W-1:0] blk_q;
    logic [BLK_W-1:0] blk_nxt;
    logic [CNT_W-1:0] fill_cnt_q;
    logic             start_q;
    logic             final_byte;

    // Marks the byte that closes the block: last flag or sixteenth slot.
    assign final_byte = in_last || (fill_cnt_q == CNT_W'(BLK_BYTES - 1));

    // Writes the incoming byte into the slot picked by the fill count.
    always_comb begin
        blk_nxt = blk_q;
        for (int i = 0; i < BLK_BYTES; i++) begin
            if (fill_cnt_q == CNT_W'(i)) begin
                blk_nxt[BLK_W-1-i*BYTE_W -: BYTE_W] = in_data;
            end
        end
    end

    // Sequences fill, hold and release of the block register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= FILL_OPEN;
            blk_q      <= '0;
            fill_cnt_q <= '0;
            start_q    <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state_q)
                FILL_OPEN: begin
                    if (in_valid) begin
                        blk_q      <= blk_nxt;
                        fill_cnt_q <= fill_cnt_q + 1'b1;
                        if (final_byte) begin
                            state_q <= FILL_HELD;
                            start_q <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (release_i) begin
                        state_q    <= FILL_OPEN;
                        fill_cnt_q <= '0;
                        blk_q      <= '0;
                    end
                end
            endcase
        end
    end

    assign in_ready  = (state_q == FILL_OPEN);
    assign blk_start = start_q;
    assign blk_data  = blk_q;
    assign blk_count = fill_cnt_q;

    // Flags any slot at or past the count that is not zero.
    logic [BLK_BYTES-1:0] pad_bad;
    for (genvar g = 0; g < BLK_BYTES; g++) begin : g_pad
        assign pad_bad[g] = (CNT_W'(g) >= blk_count) &&
                            (blk_data[BLK_W-1-g*BYTE_W -: BYTE_W] != '0);
    end

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |=> !blk_start);
    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |-> (blk_count != '0 && blk_count <= CNT_W'(BLK_BYTES)));
    // R4
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |-> (pad_bad == '0));
    // R6
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !release_i) |=> !in_ready);
    // R11
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !release_i) |=> ($stable(blk_data) && $stable(blk_count)));
endmodule

// File: rtl/blkbuf_drain.sv
// Output drain: captures the engine result on done and sends it one byte
// per valid/ready handshake, most significant byte first.
// Assumes done pulses that arrive while a result is held may be dropped.
module blkbuf_drain #(
    parameter int BYTE_W    = 8,
    parameter int BLK_BYTES = 16,
    localparam int BLK_W    = BYTE_W * BLK_BYTES,
    localparam int IDX_W    = $clog2(BLK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_done,
    input  logic [BLK_W-1:0]  eng_result,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              drained_o
);
    logic [BLK_W-1:0] shift_q;
    logic [IDX_W-1:0] idx_q;
    logic             valid_q;
    logic             fire;

    // A byte moves when both sides agree in the same cycle.
    assign fire = valid_q && out_ready;

    // Captures a result when idle, otherwise shifts on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            idx_q   <= '0;
            valid_q <= 1'b0;
        end else if (!valid_q) begin
            if (eng_done) begin
                shift_q <= eng_result;
                idx_q   <= '0;
                valid_q <= 1'b1;
            end
        end else if (fire) begin
            shift_q <= shift_q << BYTE_W;
            idx_q   <= idx_q + 1'b1;
            if (idx_q == IDX_W'(BLK_BYTES - 1)) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_data  = shift_q[BLK_W-1 -: BYTE_W];
    assign drained_o = fire && (idx_q == IDX_W'(BLK_BYTES - 1));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R9
    drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drained_o |=> !out_valid);
    // R10
    late_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && eng_done) |=> $stable(out_data));
endmodule

// File: rtl/blk_byte_buffer.sv
// Top of the byte-serial block buffer: joins the input collector and the
// output drain so a new block opens only after the last result byte leaves.
// Assumes the engine raises done once per start strobe.
module blk_byte_buffer #(
    parameter int BYTE_W    = 8,
    parameter int BLK_BYTES = 16,
    localparam int BLK_W    = BYTE_W * BLK_BYTES,
    localparam int CNT_W    = $clog2(BLK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              blk_start,
    output logic [BLK_W-1:0]  blk_data,
    output logic [CNT_W-1:0]  blk_count,
    input  logic              eng_done,
    input  logic [BLK_W-1:0]  eng_result,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready
);
    logic drained;

    blkbuf_collect #(.BYTE_W(BYTE_W), .BLK_BYTES(BLK_BYTES)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .release_i (drained),
        .in_ready  (in_ready),
        .blk_start (blk_start),
        .blk_data  (blk_data),
        .blk_count (blk_count)
    );

    blkbuf_drain #(.BYTE_W(BYTE_W), .BLK_BYTES(BLK_BYTES)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .eng_done   (eng_done),
        .eng_result (eng_result),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .drained_o  (drained)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !out_valid && !blk_start));
    // R6
    reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drained |=> in_ready);
endmodule

// File: tb/blk_byte_buffer_tb.sv
module blk_byte_buffer_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_data = '0;
    logic         in_last = 1'b0;
    logic         in_ready;
    logic         blk_start;
    logic [127:0] blk_data;
    logic [4:0]   blk_count;
    logic         eng_done = 1'b0;
    logic [127:0] eng_result = '0;
    logic         out_valid;
    logic [7:0]   out_data;
    logic         out_ready = 1'b0;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    blk_byte_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .blk_start(blk_start),
        .blk_data(blk_data), .blk_count(blk_count), .eng_done(eng_done),
        .eng_result(eng_result), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected block: byte i at the i-th slot from the top, zero past n.
    function automatic logic [127:0] pack_block(input logic [7:0] m [16], input int n);
        logic [127:0] b = '0;
        for (int i = 0; i < 16; i++)
            if (i < n) b[127-8*i -: 8] = m[i];
        return b;
    endfunction

    function automatic logic [7:0] res_byte(input logic [127:0] r, input int idx);
        return r[127-8*idx -: 8];
    endfunction

    task automatic run_block(input int n, input bit stall_out, input bit late_done);
        logic [7:0]   msg [16];
        logic [127:0] exp_blk;
        logic [127:0] res;
        logic [127:0] junk;
        int idx;
        bit rdy;
        for (int i = 0; i < 16; i++) msg[i] = 8'($urandom);
        exp_blk = pack_block(msg, n);
        res  = {$urandom, $urandom, $urandom, $urandom};
        junk = ~res;
        for (int k = 0; k < n; k++) begin
            in_valid = 1'b1; in_data = msg[k]; in_last = (k == n - 1);
            @(posedge clk); @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
            if (k != n - 1) begin
                chk(blk_start == 1'b0, "R3 no early start", 128'(blk_start), 0);
                if ($urandom % 3 == 0) begin @(posedge clk); @(negedge clk); end
            end
        end
        chk(blk_start == 1'b1, (n == 16) ? "R3 start" : "R4 start", 128'(blk_start), 1);
        chk(blk_count == 5'(n), (n == 16) ? "R3 count" : "R4 count", 128'(blk_count), 128'(n));
        chk(blk_data == exp_blk, "R2 R4 block data", blk_data, exp_blk);
        chk(in_ready == 1'b0, "R6 closed at start", 128'(in_ready), 0);
        // R11: junk offered while closed
        in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(blk_start == 1'b0, "R5 one cycle strobe", 128'(blk_start), 0);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk(blk_start == 1'b0 && blk_data == exp_blk, "R11 closed input ignored", blk_data, exp_blk);
        // engine returns a result
        eng_done = 1'b1; eng_result = res;
        @(posedge clk); @(negedge clk);
        eng_done = 1'b0;
        chk(out_valid == 1'b1, "R7 out valid", 128'(out_valid), 1);
        chk(out_data == res_byte(res, 0), "R7 first byte", 128'(out_data), 128'(res_byte(res, 0)));
        idx = 0;
        while (idx < 16) begin
            chk(out_valid == 1'b1 && out_data == res_byte(res, idx), "R8 R9 R10 byte order",
                128'(out_data), 128'(res_byte(res, idx)));
            chk(in_ready == 1'b0, "R6 closed while draining", 128'(in_ready), 0);
            rdy = stall_out ? ($urandom % 2 == 1) : 1'b1;
            out_ready = rdy;
            eng_done = late_done && (idx == 3);
            eng_result = junk;
            @(posedge clk);
            if (rdy) idx++;
            @(negedge clk);
        end
        out_ready = 1'b0; eng_done = 1'b0;
        chk(out_valid == 1'b0, "R9 idle after 16", 128'(out_valid), 0);
        chk(in_ready == 1'b1, "R6 reopen", 128'(in_ready), 1);
        chk(blk_data == '0, "R11 fresh block", blk_data, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        chk(in_ready == 1'b1, "R1 in_ready", 128'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid", 128'(out_valid), 0);
        chk(blk_start == 1'b0, "R1 blk_start", 128'(blk_start), 0);
        run_block(16, 1'b0, 1'b0);
        run_block(1, 1'b1, 1'b1);
        run_block(15, 1'b1, 1'b0);
        run_block(16, 1'b1, 1'b1);
        for (int b = 0; b < 20; b++)
            run_block(1 + int'($urandom % 16), 1'b1, ($urandom % 2) == 1);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule